// File: doc/BRIEF.md
# Status Register Field Write Unit

This block holds two 32-bit processor status words: the live (current) word and one saved copy. A single write port updates either word one byte lane at a time. A four-bit field mask picks the lanes. Privilege rules cut that mask down before anything is written.

The write data comes from one of two sources:
- a full 32-bit register operand, or
- an 8-bit immediate, rotated into place by a 4-bit rotate amount.

A separate read strobe returns the whole selected word on the following cycle. Both words are also visible at all times on their own output pins.

The block sits beside the execute stage of a processor core. The core supplies the current privilege mode as a plain input. All pins are plain control and data pins. There is no stream traffic, so no valid/ready handshake and no back-pressure.

Top module: `psr_field_writer`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets the current word to 32'h0000_00D3 and clears the saved word and `rd_data`. The value 32'h0000_00D3 means supervisor mode (bits 4:0 = 5'b10011), both interrupt-disable bits (bit 7 and bit 6) set, the compressed-state bit 5 clear, and all flags clear.
- R2: `sel_saved` = 0 targets the current word and `sel_saved` = 1 targets the saved word, for both writes and reads.
- R3: Mask bit 0 enables bits 7:0 (control lane). Bit 1 enables bits 15:8, bit 2 enables bits 23:16, and bit 3 enables bits 31:24 (flag lane). Lanes whose mask bit is 0 keep their value. Mask 4'b1111 writes the whole word.
- R4: When `cur_mode` is 5'b10000 (user), a write can change only bits 31:24 of the current word. The flags sit in that lane: N at bit 31, Z at 30, C at 29, V at 28.
- R5: When `cur_mode` is 5'b10000, a write that selects the saved word changes nothing.
- R6: An immediate-form write (`use_imm` = 1) can change only bits 31:24, in any mode.
- R7: The immediate data is `imm_val` zero-extended to 32 bits and rotated right by 2×`imm_rot` bit positions.
- R8: When `rd_en` is high at an edge, `rd_data` takes the full 32-bit value that the selected word held before that edge. When `rd_en` is low, `rd_data` holds its value.
- R9: When `wr_en` is low, neither word changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| sel_saved | input | 1 | 1 selects the saved word, 0 the current word |
| field_mask | input | 4 | Byte-lane write enables (bit 3 = flag lane) |
| use_imm | input | 1 | 1 takes the rotated immediate, 0 the register operand |
| reg_operand | input | 32 | Register-form write data |
| imm_val | input | 8 | Immediate value |
| imm_rot | input | 4 | Rotate amount, in units of two bits |
| rd_en | input | 1 | Read strobe |
| cur_mode | input | 5 | Privilege mode of the issuing instruction |
| rd_data | output | 32 | Registered read data |
| cur_psr | output | 32 | Current status word |
| saved_psr | output | 32 | Saved status word |

## Verification
The stimulus is built to tell lanes apart:
- Register operands with a different byte in every lane show whether each mask bit reaches exactly its own lane.
- Sparse masks (single-bit and alternating) catch swapped or merged lane enables.

The stimulus is also built to tell modes and sources apart:
- The same full-mask write is issued in supervisor mode and in user mode, and to each word. This separates the user-mode lane limit from the ban on writing the saved word.
- Immediate writes use even and odd rotate amounts, with non-symmetric values. A plain rotate by the raw field, a left rotate, or a missing flag-lane limit each gives a different flag byte.
- A read issued in the same cycle as a write shows whether `rd_data` takes the value from before or after the write.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int PSR_W     = 32;
  localparam int LANE_W    = 8;
  localparam int MODE_W    = 5;
  localparam logic [MODE_W-1:0] MODE_USER = 5'b10000;
  localparam logic [MODE_W-1:0] MODE_SVC  = 5'b10011;
  // supervisor mode, both interrupt disables set, flags clear
  localparam logic [PSR_W-1:0] CUR_RST_VAL = {24'h0, 1'b1, 1'b1, 1'b0, MODE_SVC};
  localparam logic [PSR_W-1:0] SAV_RST_VAL = '0;
endpackage

// File: rtl/psr_imm_rotate.sv
module psr_imm_rotate #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 8,
  parameter int ROT_W  = 4
) (
  input  logic [IMM_W-1:0]  imm,
  input  logic [ROT_W-1:0]  rot,
  output logic [DATA_W-1:0] rotated
);
  localparam int AMT_W = ROT_W + 1;

  logic [DATA_W-1:0]   ext;
  logic [2*DATA_W-1:0] dbl;
  logic [2*DATA_W-1:0] shifted;
  logic [AMT_W-1:0]    amt;

  always_comb begin
    ext     = {{(DATA_W-IMM_W){1'b0}}, imm};
    amt     = {rot, 1'b0};
    dbl     = {ext, ext};
    shifted = dbl >> amt;
    rotated = shifted[DATA_W-1:0];
  end
endmodule

// File: rtl/psr_lane_gate.sv
module psr_lane_gate #(
  parameter int LANES = 4
) (
  input  logic             wr_en,
  input  logic             sel_saved,
  input  logic             use_imm,
  input  logic             user_mode,
  input  logic [LANES-1:0] field_mask,
  output logic [LANES-1:0] cur_we,
  output logic [LANES-1:0] sav_we
);
  localparam int FLAG_LANE = LANES - 1;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam bit IS_FLAG = (k == FLAG_LANE);
    logic allow;
    // non-flag lanes need a privileged mode and a register source
    assign allow     = wr_en & field_mask[k] & (IS_FLAG | (~use_imm & ~user_mode));
    assign cur_we[k] = allow & ~sel_saved;
    assign sav_we[k] = allow & sel_saved & ~user_mode;
  end
endmodule

// File: rtl/psr_bank.sv
module psr_bank #(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  parameter logic [DATA_W-1:0] RST_VAL = '0
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [DATA_W/LANE_W-1:0] lane_we,
  input  logic [DATA_W-1:0]        wdata,
  output logic [DATA_W-1:0]        q
);
  localparam int LANES = DATA_W / LANE_W;

  logic [DATA_W-1:0] nxt;

  always_comb begin
    nxt = q;
    for (int k = 0; k < LANES; k++) begin
      if (lane_we[k]) nxt[k*LANE_W +: LANE_W] = wdata[k*LANE_W +: LANE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) q <= RST_VAL;
    else     q <= nxt;
  end
endmodule

// File: rtl/psr_field_writer.sv
module psr_field_writer
  import psr_pkg::*;
#(
  parameter int IMM_W = 8,
  parameter int ROT_W = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic                    sel_saved,
  input  logic [PSR_W/LANE_W-1:0] field_mask,
  input  logic                    use_imm,
  input  logic [PSR_W-1:0]        reg_operand,
  input  logic [IMM_W-1:0]        imm_val,
  input  logic [ROT_W-1:0]        imm_rot,
  input  logic                    rd_en,
  input  logic [MODE_W-1:0]       cur_mode,
  output logic [PSR_W-1:0]        rd_data,
  output logic [PSR_W-1:0]        cur_psr,
  output logic [PSR_W-1:0]        saved_psr
);
  localparam int LANES = PSR_W / LANE_W;

  logic [PSR_W-1:0] imm_word;
  logic [PSR_W-1:0] wdata;
  logic [LANES-1:0] cur_we;
  logic [LANES-1:0] sav_we;
  logic             user_mode;

  assign user_mode = (cur_mode == MODE_USER);

  psr_imm_rotate #(.DATA_W(PSR_W), .IMM_W(IMM_W), .ROT_W(ROT_W)) u_rot (
    .imm(imm_val), .rot(imm_rot), .rotated(imm_word)
  );

  assign wdata = use_imm ? imm_word : reg_operand;

  psr_lane_gate #(.LANES(LANES)) u_gate (
    .wr_en(wr_en), .sel_saved(sel_saved), .use_imm(use_imm),
    .user_mode(user_mode), .field_mask(field_mask),
    .cur_we(cur_we), .sav_we(sav_we)
  );

  psr_bank #(.DATA_W(PSR_W), .LANE_W(LANE_W), .RST_VAL(CUR_RST_VAL)) u_cur (
    .clk(clk), .rst(rst), .lane_we(cur_we), .wdata(wdata), .q(cur_psr)
  );

  psr_bank #(.DATA_W(PSR_W), .LANE_W(LANE_W), .RST_VAL(SAV_RST_VAL)) u_sav (
    .clk(clk), .rst(rst), .lane_we(sav_we), .wdata(wdata), .q(saved_psr)
  );

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= sel_saved ? saved_psr : cur_psr;
  end
endmodule

// File: rtl/psr_field_writer_sva.sv
module psr_field_writer_sva
  import psr_pkg::*;
(
  input logic                    clk,
  input logic                    rst,
  input logic                    wr_en,
  input logic                    sel_saved,
  input logic [PSR_W/LANE_W-1:0] field_mask,
  input logic                    use_imm,
  input logic                    rd_en,
  input logic [MODE_W-1:0]       cur_mode,
  input logic [PSR_W-1:0]        rd_data,
  input logic [PSR_W-1:0]        cur_psr,
  input logic [PSR_W-1:0]        saved_psr
);
  localparam int LANES = PSR_W / LANE_W;

  assert_user_low_lanes_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && cur_mode == MODE_USER) |=> cur_psr[PSR_W-LANE_W-1:0] == $past(cur_psr[PSR_W-LANE_W-1:0]));

  assert_user_saved_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel_saved && cur_mode == MODE_USER) |=> $stable(saved_psr));

  assert_imm_flag_only_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && use_imm) |=> (cur_psr[PSR_W-LANE_W-1:0] == $past(cur_psr[PSR_W-LANE_W-1:0]))
                        && (saved_psr[PSR_W-LANE_W-1:0] == $past(saved_psr[PSR_W-LANE_W-1:0])));

  assert_no_write_R9: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(cur_psr) && $stable(saved_psr));

  assert_read_value_R8: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_data == (sel_saved_q ? saved_q : cur_q));

  assert_read_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));

  assert_target_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !sel_saved) |=> $stable(saved_psr));

  // previous-cycle copies for the read check
  logic            sel_saved_q;
  logic [PSR_W-1:0] saved_q, cur_q;
  always_ff @(posedge clk) begin
    sel_saved_q <= sel_saved;
    saved_q     <= saved_psr;
    cur_q       <= cur_psr;
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assert_masked_lane_R3: assert property (@(posedge clk) disable iff (rst)
      (wr_en && !field_mask[k]) |=> (cur_psr[k*LANE_W +: LANE_W] == $past(cur_psr[k*LANE_W +: LANE_W]))
                                 && (saved_psr[k*LANE_W +: LANE_W] == $past(saved_psr[k*LANE_W +: LANE_W])));
  end
endmodule

bind psr_field_writer psr_field_writer_sva u_sva (
  .clk(clk), .rst(rst), .wr_en(wr_en), .sel_saved(sel_saved),
  .field_mask(field_mask), .use_imm(use_imm), .rd_en(rd_en),
  .cur_mode(cur_mode), .rd_data(rd_data), .cur_psr(cur_psr),
  .saved_psr(saved_psr)
);

// File: tb/psr_field_writer_bench.sv
`timescale 1ns/1ps
module psr_field_writer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, sel_saved = 1'b0, use_imm = 1'b0, rd_en = 1'b0;
  logic [3:0]  field_mask = '0;
  logic [31:0] reg_operand = '0;
  logic [7:0]  imm_val = '0;
  logic [3:0]  imm_rot = '0;
  logic [4:0]  cur_mode = 5'b10011;
  logic [31:0] rd_data, cur_psr, saved_psr;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  psr_field_writer u_psr_field_writer (
    .clk(clk), .rst(rst), .wr_en(wr_en), .sel_saved(sel_saved),
    .field_mask(field_mask), .use_imm(use_imm), .reg_operand(reg_operand),
    .imm_val(imm_val), .imm_rot(imm_rot), .rd_en(rd_en), .cur_mode(cur_mode),
    .rd_data(rd_data), .cur_psr(cur_psr), .saved_psr(saved_psr)
  );

  localparam logic [4:0] SVC = 5'b10011;
  localparam logic [4:0] USR = 5'b10000;
  localparam int NV = 10;
  localparam logic [4:0]  V_MODE [NV] = '{SVC, SVC, SVC, SVC, USR, USR, SVC, SVC, SVC, SVC};
  localparam logic        V_SEL  [NV] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0};
  localparam logic [3:0]  V_MASK [NV] = '{4'hF, 4'h5, 4'h2, 4'hF, 4'hF, 4'hF, 4'h8, 4'h0, 4'h1, 4'h8};
  localparam logic        V_IMM  [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1};
  localparam logic [31:0] V_OP   [NV] = '{32'hA5A55A13, 32'h11223344, 32'hFFFF77FF, 32'h0,
                                          32'h0BADCAFE, 32'hFFFFFFFF, 32'h0, 32'hFFFFFFFF, 32'h0, 32'h0};
  localparam logic [7:0]  V_IV   [NV] = '{8'h00, 8'h00, 8'h00, 8'hF0, 8'h00, 8'h00, 8'h09, 8'h00, 8'h3C, 8'h0D};
  localparam logic [3:0]  V_ROT  [NV] = '{4'd0, 4'd0, 4'd0, 4'd4, 4'd0, 4'd0, 4'd2, 4'd0, 4'd0, 4'd1};
  localparam logic [31:0] V_CUR  [NV] = '{32'hA5A55A13, 32'hA5A55A13, 32'hA5A57713, 32'hF0A57713,
                                          32'h0BA57713, 32'h0BA57713, 32'h0BA57713, 32'h0BA57713,
                                          32'h0BA57713, 32'h40A57713};
  localparam logic [31:0] V_SAV  [NV] = '{32'h0, 32'h00220044, 32'h00220044, 32'h00220044,
                                          32'h00220044, 32'h00220044, 32'h90220044, 32'h90220044,
                                          32'h90220044, 32'h90220044};
  localparam string       V_REQ  [NV] = '{"R3", "R2", "R3", "R6", "R4", "R5", "R7", "R3", "R6", "R7"};

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %08h expected %08h", req, what, act, exp);
    end
  endtask

  // called at a negedge; inputs are captured at the next posedge, returns at the following negedge
  task automatic op(input logic we, input logic re, input logic [4:0] md, input logic sel,
                    input logic [3:0] msk, input logic imm, input logic [31:0] opv,
                    input logic [7:0] iv, input logic [3:0] rot);
    wr_en = we; rd_en = re; cur_mode = md; sel_saved = sel; field_mask = msk;
    use_imm = imm; reg_operand = opv; imm_val = iv; imm_rot = rot;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1", "cur after reset", cur_psr, 32'h000000D3);
    chk("R1", "saved after reset", saved_psr, 32'h0);
    chk("R1", "rd_data after reset", rd_data, 32'h0);

    for (int i = 0; i < NV; i++) begin
      op(1'b1, 1'b0, V_MODE[i], V_SEL[i], V_MASK[i], V_IMM[i], V_OP[i], V_IV[i], V_ROT[i]);
      chk(V_REQ[i], $sformatf("vec %0d cur", i), cur_psr, V_CUR[i]);
      chk(V_REQ[i], $sformatf("vec %0d saved", i), saved_psr, V_SAV[i]);
    end

    // R8 / R2: reads of each word
    op(1'b0, 1'b1, SVC, 1'b0, 4'h0, 1'b0, 32'h0, 8'h0, 4'h0);
    chk("R8", "read current", rd_data, 32'h40A57713);
    op(1'b0, 1'b1, SVC, 1'b1, 4'h0, 1'b0, 32'h0, 8'h0, 4'h0);
    chk("R2", "read saved", rd_data, 32'h90220044);
    op(1'b0, 1'b0, SVC, 1'b0, 4'h0, 1'b0, 32'h0, 8'h0, 4'h0);
    chk("R8", "hold without rd_en", rd_data, 32'h90220044);
    // R8: read and write together returns the older value
    op(1'b1, 1'b1, SVC, 1'b0, 4'hF, 1'b0, 32'h12345678, 8'h0, 4'h0);
    chk("R8", "read during write", rd_data, 32'h40A57713);
    chk("R3", "full write", cur_psr, 32'h12345678);
    // R9: strobe low, everything else asking for a write
    op(1'b0, 1'b0, SVC, 1'b0, 4'hF, 1'b0, 32'hFFFFFFFF, 8'h0, 4'h0);
    chk("R9", "cur with wr_en low", cur_psr, 32'h12345678);
    op(1'b0, 1'b0, SVC, 1'b1, 4'hF, 1'b0, 32'hFFFFFFFF, 8'h0, 4'h0);
    chk("R9", "saved with wr_en low", saved_psr, 32'h90220044);
    // R4 / R7: user-mode immediate reaches the flag lane
    op(1'b1, 1'b0, USR, 1'b0, 4'hF, 1'b1, 32'h0, 8'hAB, 4'd4);
    chk("R4", "user imm flag write", cur_psr, 32'hAB345678);
    // R1: reset in mid-run
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1", "cur after second reset", cur_psr, 32'h000000D3);
    chk("R1", "saved after second reset", saved_psr, 32'h0);
    chk("R1", "rd_data after second reset", rd_data, 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule